// File: doc/BRIEF.md
# Address Breakpoint Match Unit

This unit watches a processor's 16-bit address bus and raises a breakpoint signal when a qualified address equals a programmed 16-bit value. Software sets the value one byte at a time through a small register port. A control register holds three bits: an enable, an output-mode select and a sticky status flag that records that a match has occurred.

The output has two modes. In pulse mode a match produces a high pulse of a fixed length, and a later match restarts that pulse. In level mode the output follows the status flag. It stays high until software writes a one to the flag, and writing a zero there leaves the flag unchanged. A debug controller or trace logic uses the output to stop or mark execution.

Top module: `addr_brk_unit`

## Requirements
- R1: All 16 address bits are compared. The match value is {high byte, low byte}, where register select 0 holds the high byte and select 1 holds the low byte. An address that differs in either byte does not match.
- R2: A match counts only while the enable bit (control bit 1) is 1. With enable at 0, a matching address leaves the flag and the output unchanged.
- R3: The breakpoint output is active high and is low when no break is pending.
- R4: With the mode bit (control bit 2) at 1, a match on a clock edge drives the output high for exactly 8 cycles, starting in the cycle after that edge. The output is then low.
- R5: With the mode bit at 0, the output is high from the cycle after a match and stays high until the status flag is cleared.
- R6: The status flag (control bit 3) is cleared by a control write with data bit 3 at 1. A control write with bit 3 at 0 leaves the flag unchanged.
- R7: Reads are combinational from the register select. Select 0 returns the high byte, select 1 the low byte, and select 2 returns {0000, flag, mode, enable, 0}. Select 3 reads 0.
- R8: A match is taken only on cycles where the address-valid strobe is 1. The flag is 1 in the cycle after the first matching cycle.
- R9: In pulse mode, a match during an active pulse restarts the count, so the output stays high for 8 cycles after the latest match.
- R10: When a match and a flag-clearing write fall in the same cycle, the match wins and the flag stays 1.
- R11: A synchronous active-high reset clears all registers and drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor address bus |
| bus_addr_vld | input | 1 | Address qualifier strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 high byte, 1 low byte, 2 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| brk_out | output | 1 | Breakpoint output, active high |

## Verification
The assertions assume the inputs are known and steady at each rising edge. They also assume the mode bit is not changed while a break is pending when level hold is checked. The bench meets the first assumption by driving all inputs only on the falling edge.

Mode changes happen only through control writes, which the level-hold property excludes from its antecedent. The stimulus covers two cases that must stay within these assumptions: a match that coincides with a clearing write, and a retrigger in the middle of a pulse. Both are driven as single-cycle events on stable inputs.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 2;
    localparam int PULSE_LEN = 8;
    localparam int CNT_W     = $clog2(PULSE_LEN + 1);

    // control bit positions
    localparam int EN_BIT    = 1;
    localparam int MODE_BIT  = 2;
    localparam int FLAG_BIT  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_HI   = 2'd0,
        SEL_LO   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic flag;
        logic pulse;
        logic en;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[EN_BIT]   = c.en;
        v[MODE_BIT] = c.pulse;
        v[FLAG_BIT] = c.flag;
        return v;
    endfunction

endpackage

// File: rtl/brk_match.sv
module brk_match
    import brk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic              en,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    assign diff = addr ^ match_addr;
    assign hit  = addr_vld && en && (diff == '0);
endmodule

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    output logic [ADDR_W-1:0] match_addr,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata
);
    localparam int LO_W = ADDR_W - DATA_W;

    reg_sel_e          sel_e;
    logic [DATA_W-1:0] hi_q;
    logic [LO_W-1:0]   lo_q;
    ctrl_t             ctrl_q;
    logic              wr_ctrl;
    logic              clr_req;

    assign sel_e   = reg_sel_e'(sel);
    assign wr_ctrl = wr && (sel_e == SEL_CTRL);
    assign clr_req = wr_ctrl && wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr && sel_e == SEL_HI) hi_q <= wdata;
            if (wr && sel_e == SEL_LO) lo_q <= wdata[LO_W-1:0];
            if (wr_ctrl) begin
                ctrl_q.en    <= wdata[EN_BIT];
                ctrl_q.pulse <= wdata[MODE_BIT];
            end
            if (hit)          ctrl_q.flag <= 1'b1;
            else if (clr_req) ctrl_q.flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel_e)
            SEL_HI:   rdata = hi_q;
            SEL_LO:   rdata = DATA_W'(lo_q);
            SEL_CTRL: rdata = pack_ctrl(ctrl_q);
            default:  rdata = '0;
        endcase
    end

    assign match_addr = {hi_q, lo_q};
    assign ctrl       = ctrl_q;

    assert_hit_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        hit |=> ctrl_q.flag);
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit) |=> !ctrl_q.flag);
    assert_zero_write_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !clr_req) |=> ctrl_q.flag);
    assert_hit_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_req) |=> ctrl_q.flag);
    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_e == SEL_NONE) |-> (rdata == '0));
endmodule

// File: rtl/brk_pulse.sv
module brk_pulse
    import brk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  ctrl_t ctrl,
    output logic  brk
);
    logic [CNT_W-1:0] cnt_q;
    logic             load;

    assign load = hit && ctrl.pulse;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= CNT_W'(PULSE_LEN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign brk = ctrl.pulse ? (cnt_q != '0) : ctrl.flag;

    assert_pulse_countdown_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    assert_pulse_restart_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == CNT_W'(PULSE_LEN)));
endmodule

// File: rtl/addr_brk_unit.sv
module addr_brk_unit
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_addr_vld,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              brk_out
);
    logic [ADDR_W-1:0] match_addr;
    ctrl_t             ctrl;
    logic              hit;
    logic              clr_wr;

    brk_match u_match (
        .addr       (bus_addr),
        .addr_vld   (bus_addr_vld),
        .match_addr (match_addr),
        .en         (ctrl.en),
        .hit        (hit)
    );

    brk_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .hit        (hit),
        .match_addr (match_addr),
        .ctrl       (ctrl),
        .rdata      (reg_rdata)
    );

    brk_pulse u_pulse (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .ctrl (ctrl),
        .brk  (brk_out)
    );

    assign clr_wr = reg_wr && (reg_sel == SEL_CTRL);

    assert_reset_low_R11: assert property (@(posedge clk)
        rst |=> !brk_out);
    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.flag) |-> $past(ctrl.en && bus_addr_vld));
    assert_level_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (brk_out && !ctrl.pulse && !clr_wr) |=> brk_out);
    assert_match_fires_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> brk_out);
endmodule

// File: tb/test_addr_brk_unit.sv
module test_addr_brk_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_addr_vld = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        brk_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_hi = 0, m_lo = 0, m_cnt = 0;
    bit m_en = 0, m_pm = 0, m_flag = 0;

    always #2 clk = ~clk;

    addr_brk_unit i_addr_brk_unit (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_addr_vld (bus_addr_vld),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .brk_out      (brk_out)
    );

    always @(posedge clk) begin
        bit hit;
        bit old_pm;
        hit = bus_addr_vld && m_en && (int'(bus_addr) == m_hi * 256 + m_lo);
        old_pm = m_pm;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_cnt = 0;
            m_en = 0; m_pm = 0; m_flag = 0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: m_hi = int'(reg_wdata);
                    2'd1: m_lo = int'(reg_wdata);
                    2'd2: begin
                        m_en = reg_wdata[1];
                        m_pm = reg_wdata[2];
                        if (reg_wdata[3]) m_flag = 0;
                    end
                    default: ;
                endcase
            end
            if (hit) m_flag = 1;
            if (hit && old_pm) m_cnt = 8;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
        end
    end

    function automatic logic exp_brk();
        return m_pm ? (m_cnt > 0) : m_flag;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [1:0] s);
        case (s)
            2'd0: return 8'(m_hi);
            2'd1: return 8'(m_lo);
            2'd2: return {4'b0, m_flag, m_pm, m_en, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one cycle: check output of previous edge, drive inputs, check read data
    task automatic step(input logic vld, input logic [15:0] a, input logic wr,
                        input logic [1:0] s, input logic [7:0] wd, input string tag);
        @(negedge clk);
        chk(tag, 16'(brk_out), 16'(exp_brk()));
        bus_addr_vld = vld;
        bus_addr     = a;
        reg_wr       = wr;
        reg_sel      = s;
        reg_wdata    = wd;
        #1;
        chk("R7 read", 16'(reg_rdata), 16'(exp_rdata(s)));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b0, 2'd2, 8'h00, tag);
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] wd, input string tag);
        step(1'b0, 16'h0000, 1'b1, s, wd, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        idle(3, "R11 reset");
        rst = 1'b0;
        // R11: every register reads 0 after reset
        for (int s = 0; s < 4; s++) step(1'b0, 16'h0, 1'b0, 2'(s), 8'h00, "R11 reset state");
        chk("R3 idle low", 16'(brk_out), 16'h0);

        // R1 program match value 0x12AB, enable, level mode
        wr_reg(2'd0, 8'h12, "R1");
        wr_reg(2'd1, 8'hAB, "R1");
        wr_reg(2'd2, 8'h02, "R1");
        // R8: matching address without strobe
        step(1'b0, 16'h12AB, 1'b0, 2'd2, 8'h00, "R8");
        idle(2, "R8 no strobe no break");
        // R1: mismatch in high byte, then in low byte
        step(1'b1, 16'h13AB, 1'b0, 2'd2, 8'h00, "R1");
        step(1'b1, 16'h12AA, 1'b0, 2'd2, 8'h00, "R1 hi mismatch");
        idle(2, "R1 lo mismatch");
        // R2: disabled
        wr_reg(2'd2, 8'h00, "R2");
        step(1'b1, 16'h12AB, 1'b0, 2'd2, 8'h00, "R2");
        idle(2, "R2 disabled no break");
        // R5 level mode
        wr_reg(2'd2, 8'h02, "R5");
        step(1'b1, 16'h12AB, 1'b0, 2'd2, 8'h00, "R5");
        idle(6, "R5 level held");
        wr_reg(2'd2, 8'h02, "R6 write0");
        idle(3, "R6 write0 keeps flag");
        wr_reg(2'd2, 8'h0A, "R6 w1c");
        idle(3, "R6 cleared");

        // R4 pulse mode
        wr_reg(2'd2, 8'h06, "R4");
        step(1'b1, 16'h12AB, 1'b0, 2'd2, 8'h00, "R4");
        idle(11, "R4 pulse window");
        // R9 retrigger
        step(1'b1, 16'h12AB, 1'b0, 2'd2, 8'h00, "R9");
        idle(3, "R9 first pulse");
        step(1'b1, 16'h12AB, 1'b0, 2'd2, 8'h00, "R9");
        idle(11, "R9 restarted pulse");

        // R10: match and clear in same cycle, level mode
        wr_reg(2'd2, 8'h0A, "R10 prep");
        idle(1, "R10 prep");
        step(1'b1, 16'h12AB, 1'b1, 2'd2, 8'h0A, "R10");
        idle(3, "R10 match wins");
        wr_reg(2'd2, 8'h0A, "R10 clear");
        idle(2, "R10 cleared");

        // R7: unused control bits read 0, select 3 reads 0
        wr_reg(2'd2, 8'hFF, "R7");
        idle(1, "R7");
        step(1'b0, 16'h0, 1'b0, 2'd3, 8'h00, "R7 sel3");
        step(1'b0, 16'h0, 1'b0, 2'd2, 8'h00, "R7 ctrl");
        chk("R7 ctrl value", 16'(reg_rdata), 16'h0006);

        // R11: reset during a level break
        wr_reg(2'd2, 8'h02, "R11");
        step(1'b1, 16'h12AB, 1'b0, 2'd2, 8'h00, "R11");
        idle(2, "R11 break set");
        rst = 1'b1;
        idle(2, "R11 in reset");
        rst = 1'b0;
        for (int s = 0; s < 4; s++) step(1'b0, 16'h0, 1'b0, 2'(s), 8'h00, "R11 after reset");
        idle(2, "R3 low after reset");

        report();
    end
endmodule